// File: doc/BRIEF.md
# Rectangular 2D Blit Engine

This block moves or fills rectangles of pixels inside a linear frame buffer holding 8-bit or 16-bit pixels. Software programs it through a byte-wide register port: it loads the source and destination byte addresses, the rectangle size, the line pitch, the pixel depth, the operation code and, for fills, a foreground colour. It then writes the control register with the launch bit set. The launch bit reads back as a busy flag until the last pixel has been written.

The engine has a read port and a write port onto a word-wide (16-bit) synchronous frame-buffer memory. Read data returns one cycle after the request. A write is taken only in a cycle where `mem_stall` is low, so the memory controller can hold the engine off while it serves display refresh. Pixels read for a move wait in a 16-entry FIFO between the reader and the writer. The reader can therefore run ahead while the writer is stalled.

A move runs in the direction that the operation code selects. A backward move starts at the last pixel of each rectangle and steps downward, so rectangles that overlap, with the destination above the source, are copied correctly.

Top module: `blit_engine`

## Requirements
- R1: After reset, control register 0 (address 0) reads 0x60 (FIFO empty, not full, idle), every parameter register reads 0, and neither memory strobe is asserted.
- R2: Parameter registers are byte-wide at these addresses: 1 depth (bit 0), 2 opcode, 3..5 source byte address, 6..8 destination byte address, 9..10 width minus one (10 bits), 11..12 height minus one (10 bits), 13..14 pitch in 16-bit words (11 bits), 15..16 foreground colour. Multi-byte values are loaded low byte first. Every register reads back the bits it stores, and unused high bits read 0.
- R3: Writing address 0 with bit 7 set while idle launches an operation. Bit 7 of address 0 reads 1 from the next cycle until the last write is taken, then reads 0. No memory strobe is asserted while idle.
- R4: While busy, writes to every register, including a second launch, are ignored.
- R5: Opcode 0x02 copies forward. Pixels run in ascending address order within a row, and the next row starts at the row start plus twice the pitch. The destination ends up holding the source rectangle.
- R6: Opcode 0x03 copies backward from the programmed last pixel of each rectangle in descending order. It gives a correct result when the destination overlaps the source at higher addresses.
- R7: Opcode 0x0C fills the destination rectangle with the foreground colour, issues no memory read, and ignores the source address.
- R8: Depth bit 1 means 16-bit pixels, written with both byte enables set. Depth bit 0 means 8-bit pixels, written with one byte enable (bit 0 for an even byte address, data in bits 7:0; bit 1 for an odd byte address, data in bits 15:8), and the neighbouring byte is preserved. Word address is byte address divided by two.
- R9: Address 0 reports bit 6 = FIFO empty, bit 5 = FIFO not full, bit 4 = FIFO full, for a 16-word FIFO. While `mem_stall` is high a pending write is held unchanged, and the reader stops once the FIFO is full.
- R10: Width and height are programmed as count minus one, and an operation writes exactly width × height pixels. A 1×1 rectangle produces one write.
- R11: Any other opcode ends the operation without any memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| mem_rd_en | output | 1 | Frame-buffer read request |
| mem_rd_addr | output | 23 | Read word address |
| mem_rd_data | input | 16 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Frame-buffer write request |
| mem_wr_addr | output | 23 | Write word address |
| mem_wr_data | output | 16 | Write data |
| mem_wr_be | output | 2 | Write byte enables |
| mem_stall | input | 1 | Holds off the write in the current cycle |

## Verification
A register write takes effect at the clock edge that samples it. The busy flag is therefore already set at the first falling edge after a launch, and the bench reads it there. Memory read data comes back one edge after the request. A write lands on the edge where `mem_stall` is low, so completion time depends on stalls. The bench does not predict it: it polls the busy bit every cycle, compares the whole memory image once busy drops, and counts accepted writes and reads on falling edges. FIFO flags are read after holding `mem_stall` for far longer than the 16 cycles the reader needs to fill the FIFO, so the full state is settled when sampled.

// File: rtl/blit_pkg.sv
package blit_pkg;

    localparam int BL_ADDR_W  = 24;
    localparam int BL_DIM_W   = 10;
    localparam int BL_PITCH_W = 11;
    localparam int BL_PIX_W   = 16;
    localparam int BL_REG_AW  = 5;

    localparam logic [7:0] OP_MOVE_FWD = 8'h02;
    localparam logic [7:0] OP_MOVE_BWD = 8'h03;
    localparam logic [7:0] OP_FILL     = 8'h0C;

    typedef enum logic [BL_REG_AW-1:0] {
        RA_CTRL   = 5'd0,
        RA_DEPTH  = 5'd1,
        RA_OPCODE = 5'd2,
        RA_SRC0   = 5'd3,
        RA_SRC1   = 5'd4,
        RA_SRC2   = 5'd5,
        RA_DST0   = 5'd6,
        RA_DST1   = 5'd7,
        RA_DST2   = 5'd8,
        RA_WID0   = 5'd9,
        RA_WID1   = 5'd10,
        RA_HGT0   = 5'd11,
        RA_HGT1   = 5'd12,
        RA_PIT0   = 5'd13,
        RA_PIT1   = 5'd14,
        RA_FG0    = 5'd15,
        RA_FG1    = 5'd16
    } reg_addr_e;

    typedef struct packed {
        logic [BL_ADDR_W-1:0]  src;
        logic [BL_ADDR_W-1:0]  dst;
        logic [BL_DIM_W-1:0]   wm1;
        logic [BL_DIM_W-1:0]   hm1;
        logic [BL_PITCH_W-1:0] pitch;
        logic [7:0]            op;
        logic                  d16;
        logic [BL_PIX_W-1:0]   fg;
    } blit_cfg_t;

endpackage

// File: rtl/blit_regfile.sv
module blit_regfile
    import blit_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [BL_REG_AW-1:0] addr,
    input  logic [7:0]           wdata,
    input  logic                 busy,
    input  logic                 fifo_empty,
    input  logic                 fifo_full,
    output logic [7:0]           rdata,
    output blit_cfg_t            cfg,
    output logic                 start
);

    blit_cfg_t cfg_d, cfg_q;
    logic      wr_ok;

    assign wr_ok = wr_en && !busy;
    assign start = wr_ok && (addr == RA_CTRL) && wdata[7];
    assign cfg   = cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ok) begin
            case (addr)
                RA_DEPTH:  cfg_d.d16         = wdata[0];
                RA_OPCODE: cfg_d.op          = wdata;
                RA_SRC0:   cfg_d.src[7:0]    = wdata;
                RA_SRC1:   cfg_d.src[15:8]   = wdata;
                RA_SRC2:   cfg_d.src[23:16]  = wdata;
                RA_DST0:   cfg_d.dst[7:0]    = wdata;
                RA_DST1:   cfg_d.dst[15:8]   = wdata;
                RA_DST2:   cfg_d.dst[23:16]  = wdata;
                RA_WID0:   cfg_d.wm1[7:0]    = wdata;
                RA_WID1:   cfg_d.wm1[BL_DIM_W-1:8] = wdata[BL_DIM_W-9:0];
                RA_HGT0:   cfg_d.hm1[7:0]    = wdata;
                RA_HGT1:   cfg_d.hm1[BL_DIM_W-1:8] = wdata[BL_DIM_W-9:0];
                RA_PIT0:   cfg_d.pitch[7:0]  = wdata;
                RA_PIT1:   cfg_d.pitch[BL_PITCH_W-1:8] = wdata[BL_PITCH_W-9:0];
                RA_FG0:    cfg_d.fg[7:0]     = wdata;
                RA_FG1:    cfg_d.fg[15:8]    = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = 8'h00;
        case (addr)
            RA_CTRL:   rdata = {busy, fifo_empty, !fifo_full, fifo_full, 4'b0000};
            RA_DEPTH:  rdata = {7'b0, cfg_q.d16};
            RA_OPCODE: rdata = cfg_q.op;
            RA_SRC0:   rdata = cfg_q.src[7:0];
            RA_SRC1:   rdata = cfg_q.src[15:8];
            RA_SRC2:   rdata = cfg_q.src[23:16];
            RA_DST0:   rdata = cfg_q.dst[7:0];
            RA_DST1:   rdata = cfg_q.dst[15:8];
            RA_DST2:   rdata = cfg_q.dst[23:16];
            RA_WID0:   rdata = cfg_q.wm1[7:0];
            RA_WID1:   rdata = 8'(cfg_q.wm1[BL_DIM_W-1:8]);
            RA_HGT0:   rdata = cfg_q.hm1[7:0];
            RA_HGT1:   rdata = 8'(cfg_q.hm1[BL_DIM_W-1:8]);
            RA_PIT0:   rdata = cfg_q.pitch[7:0];
            RA_PIT1:   rdata = 8'(cfg_q.pitch[BL_PITCH_W-1:8]);
            RA_FG0:    rdata = cfg_q.fg[7:0];
            RA_FG1:    rdata = cfg_q.fg[15:8];
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
    parameter int AW = 24,
    parameter int DW = 10,
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] start_addr,
    input  logic [DW-1:0] wm1,
    input  logic [DW-1:0] hm1,
    input  logic [PW-1:0] pitch,
    input  logic          d16,
    input  logic          dir_neg,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          last
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [AW-1:0] row;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
    } walk_t;

    walk_t st_d, st_q;
    logic [AW-1:0] bpp;
    logic [AW-1:0] pitch_b;
    logic [AW-1:0] next_row;

    assign bpp     = d16 ? AW'(2) : AW'(1);
    assign pitch_b = AW'({pitch, 1'b0});
    assign addr    = st_q.addr;
    assign last    = (st_q.x == wm1) && (st_q.y == hm1);

    always_comb begin
        st_d     = st_q;
        next_row = dir_neg ? (st_q.row - pitch_b) : (st_q.row + pitch_b);
        if (load) begin
            st_d.addr = start_addr;
            st_d.row  = start_addr;
            st_d.x    = '0;
            st_d.y    = '0;
        end else if (step) begin
            if (st_q.x == wm1) begin
                st_d.x    = '0;
                st_d.y    = st_q.y + 1'b1;
                st_d.row  = next_row;
                st_d.addr = next_row;
            end else begin
                st_d.x    = st_q.x + 1'b1;
                st_d.addr = dir_neg ? (st_q.addr - bpp) : (st_q.addr + bpp);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/blit_fifo.sv
module blit_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rp;
        logic [PTR_W-1:0]        wp;
        logic [CNT_W-1:0]        cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNT_W'(DEPTH));
    assign count   = st_q.cnt;
    assign rdata   = st_q.mem[st_q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (do_pop) st_d.rp = ptr_inc(st_q.rp);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic [BL_REG_AW-1:0] reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 mem_rd_en,
    output logic [BL_ADDR_W-2:0] mem_rd_addr,
    input  logic [BL_PIX_W-1:0]  mem_rd_data,
    output logic                 mem_wr_en,
    output logic [BL_ADDR_W-2:0] mem_wr_addr,
    output logic [BL_PIX_W-1:0]  mem_wr_data,
    output logic [1:0]           mem_wr_be,
    input  logic                 mem_stall
);

    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    typedef struct packed {
        logic busy;
        logic rd_more;
        logic inflight;
        logic tag;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    blit_cfg_t          cfg_w;
    logic               busy_w;
    logic               start;
    logic               op_fwd, op_bwd, op_fill, op_move;
    logic               rd_issue, wr_valid, wr_take, pop;
    logic [BL_ADDR_W-1:0] src_addr, dst_addr;
    logic               src_last, dst_last;
    logic [BL_PIX_W-1:0] push_data, fifo_head, pix;
    logic [CNT_W-1:0]   fifo_cnt_w;
    logic               fifo_empty, fifo_full;
    logic [CNT_W:0]     pending;

    assign busy_w  = ctl_q.busy;
    assign op_fwd  = (cfg_w.op == OP_MOVE_FWD);
    assign op_bwd  = (cfg_w.op == OP_MOVE_BWD);
    assign op_fill = (cfg_w.op == OP_FILL);
    assign op_move = op_fwd || op_bwd;

    blit_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .busy       (busy_w),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .rdata      (reg_rdata),
        .cfg        (cfg_w),
        .start      (start)
    );

    blit_walker #(.AW(BL_ADDR_W), .DW(BL_DIM_W), .PW(BL_PITCH_W)) u_src_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .start_addr (cfg_w.src),
        .wm1        (cfg_w.wm1),
        .hm1        (cfg_w.hm1),
        .pitch      (cfg_w.pitch),
        .d16        (cfg_w.d16),
        .dir_neg    (op_bwd),
        .step       (rd_issue),
        .addr       (src_addr),
        .last       (src_last)
    );

    blit_walker #(.AW(BL_ADDR_W), .DW(BL_DIM_W), .PW(BL_PITCH_W)) u_dst_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start),
        .start_addr (cfg_w.dst),
        .wm1        (cfg_w.wm1),
        .hm1        (cfg_w.hm1),
        .pitch      (cfg_w.pitch),
        .d16        (cfg_w.d16),
        .dir_neg    (op_bwd),
        .step       (wr_take),
        .addr       (dst_addr),
        .last       (dst_last)
    );

    blit_fifo #(.W(BL_PIX_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ctl_q.inflight),
        .wdata (push_data),
        .pop   (pop),
        .rdata (fifo_head),
        .count (fifo_cnt_w),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    // Reader: one word per cycle while the FIFO, counting the read in flight, has room.
    assign pending   = {1'b0, fifo_cnt_w} + (CNT_W+1)'(ctl_q.inflight);
    assign rd_issue  = ctl_q.busy && op_move && ctl_q.rd_more &&
                       (pending < (CNT_W+1)'(FIFO_DEPTH));
    assign mem_rd_en   = rd_issue;
    assign mem_rd_addr = src_addr[BL_ADDR_W-1:1];
    assign push_data   = cfg_w.d16 ? mem_rd_data
                       : {8'h00, (ctl_q.tag ? mem_rd_data[15:8] : mem_rd_data[7:0])};

    // Writer: fill needs no data, a move waits for the FIFO head.
    assign wr_valid = ctl_q.busy && (op_fill || (op_move && !fifo_empty));
    assign wr_take  = wr_valid && !mem_stall;
    assign pop      = wr_take && op_move;
    assign pix      = op_fill ? cfg_w.fg : fifo_head;

    assign mem_wr_en   = wr_valid;
    assign mem_wr_addr = dst_addr[BL_ADDR_W-1:1];
    assign mem_wr_data = cfg_w.d16 ? pix : {pix[7:0], pix[7:0]};
    assign mem_wr_be   = cfg_w.d16 ? 2'b11 : (dst_addr[0] ? 2'b10 : 2'b01);

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.inflight = rd_issue;
        ctl_d.tag      = src_addr[0];
        if (start) begin
            ctl_d.busy    = 1'b1;
            ctl_d.rd_more = 1'b1;
        end else if (ctl_q.busy) begin
            if (rd_issue && src_last) ctl_d.rd_more = 1'b0;
            if (!(op_move || op_fill) || (wr_take && dst_last)) begin
                ctl_d.busy    = 1'b0;
                ctl_d.rd_more = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk
    import blit_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         busy,
    input blit_cfg_t                    cfg,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
    input logic                         mem_rd_en,
    input logic                         mem_wr_en,
    input logic [BL_ADDR_W-2:0]         mem_wr_addr,
    input logic [BL_PIX_W-1:0]          mem_wr_data,
    input logic [1:0]                   mem_wr_be,
    input logic                         mem_stall
);

    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    a_r4_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg));

    a_r7_fill_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg.op == OP_FILL) |-> !mem_rd_en);

    a_r8_wide_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && cfg.d16) |-> (mem_wr_be == 2'b11));

    a_r8_narrow_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && !cfg.d16) |-> ($countones(mem_wr_be) == 1));

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH));

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_stall) |=>
        (mem_wr_en && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_be)));

endmodule

bind blit_engine blit_engine_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy_w),
    .cfg         (cfg_w),
    .fifo_cnt    (fifo_cnt_w),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .mem_wr_be   (mem_wr_be),
    .mem_stall   (mem_stall)
);

// File: tb/blit_engine_tb.sv
module blit_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_rd_en;
    logic [22:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        mem_wr_en;
    logic [22:0] mem_wr_addr;
    logic [15:0] mem_wr_data;
    logic [1:0]  mem_wr_be;
    logic        mem_stall = 1'b0;

    int n_total = 0;
    int n_pass  = 0;
    int wr_seen = 0;
    int rd_seen = 0;

    logic [15:0] fbmem [0:1023];
    logic [7:0]  expb  [0:2047];
    logic [7:0]  snap  [0:2047];

    always #10 clk = ~clk;

    blit_engine u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .mem_wr_be   (mem_wr_be),
        .mem_stall   (mem_stall)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= fbmem[mem_rd_addr[9:0]];
        if (mem_wr_en && !mem_stall) begin
            if (mem_wr_be[0]) fbmem[mem_wr_addr[9:0]][7:0]  <= mem_wr_data[7:0];
            if (mem_wr_be[1]) fbmem[mem_wr_addr[9:0]][15:8] <= mem_wr_data[15:8];
        end
    end

    always @(negedge clk) begin
        if (mem_wr_en && !mem_stall) wr_seen++;
        if (mem_rd_en) rd_seen++;
    end

    typedef struct packed {
        logic [7:0]  op;
        logic        d16;
        logic [7:0]  sx, sy, dx, dy, w, h, pw;
        logic [15:0] fg;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{8'h02, 1'b0, 8'd3, 8'd2,  8'd10, 8'd20, 8'd5, 8'd4, 8'd16, 16'h0000},
        '{8'h02, 1'b1, 8'd1, 8'd1,  8'd4,  8'd30, 8'd6, 8'd3, 8'd12, 16'h0000},
        '{8'h03, 1'b0, 8'd2, 8'd5,  8'd4,  8'd6,  8'd7, 8'd5, 8'd16, 16'h0000},
        '{8'h03, 1'b1, 8'd0, 8'd10, 8'd1,  8'd10, 8'd8, 8'd2, 8'd16, 16'h0000},
        '{8'h02, 1'b0, 8'd5, 8'd40, 8'd3,  8'd39, 8'd6, 8'd3, 8'd16, 16'h0000},
        '{8'h0C, 1'b0, 8'd0, 8'd0,  8'd7,  8'd50, 8'd5, 8'd3, 8'd16, 16'h12A5},
        '{8'h0C, 1'b1, 8'd0, 8'd0,  8'd2,  8'd55, 8'd4, 8'd2, 8'd16, 16'hBEEF},
        '{8'h02, 1'b0, 8'd9, 8'd0,  8'd13, 8'd60, 8'd1, 8'd1, 8'd16, 16'h0000}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] mem_byte(input int a);
        return a[0] ? fbmem[a >> 1][15:8] : fbmem[a >> 1][7:0];
    endfunction

    task automatic prog(input logic [7:0] op, input logic d16, input int src, input int dst,
                        input int wm1, input int hm1, input int pitch, input logic [15:0] fg);
        reg_wr(5'd1, {7'b0, d16});
        reg_wr(5'd2, op);
        reg_wr(5'd3, src[7:0]);   reg_wr(5'd4, src[15:8]);  reg_wr(5'd5, src[23:16]);
        reg_wr(5'd6, dst[7:0]);   reg_wr(5'd7, dst[15:8]);  reg_wr(5'd8, dst[23:16]);
        reg_wr(5'd9, wm1[7:0]);   reg_wr(5'd10, wm1[15:8]);
        reg_wr(5'd11, hm1[7:0]);  reg_wr(5'd12, hm1[15:8]);
        reg_wr(5'd13, pitch[7:0]); reg_wr(5'd14, pitch[15:8]);
        reg_wr(5'd15, fg[7:0]);   reg_wr(5'd16, fg[15:8]);
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] d;
        int n = 0;
        reg_rd(5'd0, d);
        while (d[7] && n < 3000) begin
            reg_rd(5'd0, d);
            n++;
        end
        check(!d[7], req, "busy flag clears", int'(d), 32'h60);
    endtask

    task automatic compare_mem(input string req, input string what);
        int bad = 0;
        int first = -1;
        for (int a = 0; a < 2048; a++) begin
            if (mem_byte(a) !== expb[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        end
        if (first < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, {what, " byte"}, int'(mem_byte(first)), int'(expb[first]));
        for (int a = 0; a < 2048; a++) expb[a] = mem_byte(a);
    endtask

    task automatic model_op(input vec_t v);
        int bpp = v.d16 ? 2 : 1;
        int pb  = int'(v.pw) * 2;
        for (int a = 0; a < 2048; a++) snap[a] = expb[a];
        for (int y = 0; y < int'(v.h); y++)
            for (int x = 0; x < int'(v.w); x++)
                for (int b = 0; b < bpp; b++) begin
                    int so = (int'(v.sy) + y) * pb + (int'(v.sx) + x) * bpp + b;
                    int dof = (int'(v.dy) + y) * pb + (int'(v.dx) + x) * bpp + b;
                    if (v.op == 8'h0C) expb[dof] = v.d16 ? v.fg[8*b +: 8] : v.fg[7:0];
                    else               expb[dof] = snap[so];
                end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int bpp = v.d16 ? 2 : 1;
        int pb  = int'(v.pw) * 2;
        int s, d, w0, r0;
        logic [7:0] st;
        string req;
        if (v.op == 8'h03) begin
            s = (int'(v.sy) + int'(v.h) - 1) * pb + (int'(v.sx) + int'(v.w) - 1) * bpp;
            d = (int'(v.dy) + int'(v.h) - 1) * pb + (int'(v.dx) + int'(v.w) - 1) * bpp;
            req = "R6";
        end else begin
            s = int'(v.sy) * pb + int'(v.sx) * bpp;
            d = int'(v.dy) * pb + int'(v.dx) * bpp;
            req = (v.op == 8'h0C) ? "R7" : "R5";
        end
        if (v.op == 8'h0C) s = 32'h00ABCDE;
        prog(v.op, v.d16, s, d, int'(v.w) - 1, int'(v.h) - 1, int'(v.pw), v.fg);
        model_op(v);
        w0 = wr_seen;
        r0 = rd_seen;
        reg_wr(5'd0, 8'h80);
        reg_rd(5'd0, st);
        check(st[7], "R3", $sformatf("busy after launch, vector %0d", idx), int'(st[7]), 1);
        wait_idle("R3");
        compare_mem(req, $sformatf("image (R8 lanes), vector %0d", idx));
        check(wr_seen - w0 == int'(v.w) * int'(v.h), "R10",
              $sformatf("write count, vector %0d", idx), wr_seen - w0, int'(v.w) * int'(v.h));
        if (v.op == 8'h0C)
            check(rd_seen == r0, "R7", $sformatf("reads during fill, vector %0d", idx), rd_seen - r0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] mask;
        int w0, r0;
        for (int i = 0; i < 1024; i++) fbmem[i] = 16'(i * 40503) ^ 16'h5A3C;
        for (int a = 0; a < 2048; a++) expb[a] = mem_byte(a);

        repeat (3) @(negedge clk);
        // R1 reset state
        reg_rd(5'd0, d);
        check(d == 8'h60, "R1", "ctrl0 after reset", int'(d), 32'h60);
        reg_rd(5'd6, d);
        check(d == 8'h00, "R1", "dst low after reset", int'(d), 0);
        check(!mem_rd_en && !mem_wr_en, "R1", "memory strobes in reset",
              int'({mem_rd_en, mem_wr_en}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        reg_rd(5'd0, d);
        check(d == 8'h60, "R1", "ctrl0 after release", int'(d), 32'h60);

        // R2 register readback with stored-bit masks
        for (int a = 1; a <= 17; a++) begin
            mask = (a == 1) ? 8'h01 : (a == 10 || a == 12) ? 8'h03 :
                   (a == 14) ? 8'h07 : (a == 17) ? 8'h00 : 8'hFF;
            reg_wr(5'(a), 8'(8'hA7 + a * 13));
            reg_rd(5'(a), d);
            check(d == (8'(8'hA7 + a * 13) & mask), "R2", $sformatf("readback reg %0d", a),
                  int'(d), int'(8'(8'hA7 + a * 13) & mask));
        end

        // Vector table: R5 R6 R7 R8 R10
        for (int i = 0; i < 8; i++) run_vec(VECS[i], i);

        // R9 FIFO flags with stalled writer
        begin
            vec_t v;
            v = '{8'h02, 1'b1, 8'd0, 8'd20, 8'd0, 8'd45, 8'd12, 8'd2, 8'd16, 16'h0};
            prog(v.op, v.d16, 20 * 32, 45 * 32, 11, 1, 16, 16'h0);
            model_op(v);
            mem_stall = 1'b1;
            w0 = wr_seen;
            reg_wr(5'd0, 8'h80);
            repeat (30) @(negedge clk);
            reg_rd(5'd0, d);
            check(d == 8'h90, "R9", "ctrl0 with FIFO full", int'(d), 32'h90);
            check(wr_seen == w0, "R9", "writes while stalled", wr_seen - w0, 0);
            mem_stall = 1'b0;
            wait_idle("R9");
            reg_rd(5'd0, d);
            check(d == 8'h60, "R9", "ctrl0 after drain", int'(d), 32'h60);
            compare_mem("R9", "image after stalled copy");
        end

        // R4 writes ignored while busy
        begin
            vec_t v;
            v = '{8'h0C, 1'b0, 8'd0, 8'd0, 8'd1, 8'd62, 8'd1, 8'd1, 8'd16, 16'h0033};
            prog(8'h0C, 1'b0, 0, 62 * 32 + 1, 0, 0, 16, 16'h0033);
            model_op(v);
            mem_stall = 1'b1;
            reg_wr(5'd0, 8'h80);
            reg_rd(5'd0, d);
            check(d == 8'hE0, "R3", "ctrl0 while busy and empty", int'(d), 32'hE0);
            reg_wr(5'd6, 8'h77);
            reg_rd(5'd6, d);
            check(d == 8'hC1, "R4", "dst low write while busy", int'(d), 32'hC1);
            reg_wr(5'd2, 8'h02);
            reg_rd(5'd2, d);
            check(d == 8'h0C, "R4", "opcode write while busy", int'(d), 32'h0C);
            mem_stall = 1'b0;
            wait_idle("R4");
            compare_mem("R4", "image after 1x1 fill");
        end

        // R11 unknown opcode
        prog(8'h07, 1'b0, 100, 300, 3, 3, 16, 16'hFFFF);
        w0 = wr_seen;
        r0 = rd_seen;
        reg_wr(5'd0, 8'h80);
        wait_idle("R11");
        check(wr_seen == w0 && rd_seen == r0, "R11", "memory accesses for unknown opcode",
              (wr_seen - w0) + (rd_seen - r0), 0);
        compare_mem("R11", "image after unknown opcode");

        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

endmodule